// File: doc/BRIEF.md
# Asynchronous Link Control Register

A 32-bit control register for the asynchronous transmit and receive paths of a serial-bus link layer. Software writes and reads it through a simple word-wide port. Most fields are plain storage that drive the packet logic directly:

- a broadcast-reception disable (broadcast means packets addressed to node 0x3F);
- a response-filter mode;
- a retry limit;
- a two-part timeout, in whole seconds and in 1/8000 s fractions.

Two bits also change without a software write. The receiver-reset bit clears itself once the link state machine reports idle. The transmitter-reset bit is forced on by every bus-reset event and stays on until software writes it back to 0.

Each self-modifying bit is handled by its own two-state machine. Receiver reset has the states RX_RUN and RX_HOLD:

- RX_RUN goes to RX_HOLD on a write that sets the bit (transition RX_ARM).
- RX_HOLD returns to RX_RUN on a write that clears the bit (RX_DROP).
- RX_HOLD also returns to RX_RUN on idle when no write sets the bit in that cycle (RX_AUTOCLR).

Transmitter reset has the states TX_LIVE and TX_HELD:

- Any state goes to TX_HELD on a bus reset (TX_FORCE).
- Otherwise a write moves to TX_HELD if the bit is set (TX_SET), or to TX_LIVE if it is clear (TX_RELEASE).
- TX_HELD is also the state after reset, so that the register comes up as 0x00300320.

The outputs are registered. A change is visible on the outputs and on the readback one clock after the event that caused it.

Top module: `async_link_ctl`

## Requirements
- R1: After reset the readback is 0x00300320. This means receiver reset is 0, transmitter reset is 1, response-all is 1, broadcast disable is 0, retry limit is 0, seconds is 0 and fraction is 0x320.
- R2: A write stores wr_data bits 23 (broadcast disable), 20 (response-all), 19..16 (retry limit), 15..13 (seconds) and 12..0 (fraction). These values appear on their outputs and in rd_data on the next clock.
- R3: rd_data bits 31..24 always read 0, whatever was written to them.
- R4: A write with bit 22 = 1 sets rx_rst on the next clock. rx_rst then holds while link_idle is low and no write clears it.
- R5: While rx_rst is set, link_idle high clears it on the next clock, unless a write with bit 22 = 1 happens in the same cycle. In that case the bit stays set.
- R6: A write with bit 22 = 0 clears rx_rst on the next clock.
- R7: A bus_reset pulse sets tx_rst on the next clock, even if a write of bit 21 = 0 happens in the same cycle.
- R8: Without a bus reset, a write sets tx_rst to wr_data bit 21 on the next clock.
- R9: In a cycle with no write, every field except the self-modifying bits keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_data | input | 32 | Write word |
| bus_reset | input | 1 | Bus-reset event pulse |
| link_idle | input | 1 | Link state machine is idle |
| rd_data | output | 32 | Current register contents |
| bcast_off | output | 1 | Broadcast reception disabled |
| rx_rst | output | 1 | Async receiver held in reset |
| tx_rst | output | 1 | Async transmitter held in reset |
| rsp_all | output | 1 | Store all responses (0: solicited only) |
| retry_max | output | 4 | Maximum single-phase retries |
| tmo_sec | output | 3 | Timeout whole seconds |
| tmo_frac | output | 13 | Timeout fractions of 1/8000 s |

## Verification
Each state machine drives its output bit directly. A wrong state therefore shows on rx_rst or tx_rst, and in rd_data, one clock after the event that caused it. The cases that need the most care are the same-cycle collisions: a bus reset against a write of 0 to bit 21, and idle against a write to bit 22. A wrong priority at either one leaves the bit wrong for the whole following cycle. A field that was lost or moved shows in the readback as soon as the write after it is sampled.

// File: rtl/alc_pkg.sv
package alc_pkg;
    localparam int WORD_W   = 32;
    localparam int RETRY_W  = 4;
    localparam int SEC_W    = 3;
    localparam int FRAC_W   = 13;
    localparam int FRAC_LSB = 0;
    localparam int SEC_LSB  = FRAC_LSB + FRAC_W;
    localparam int RETRY_LSB = SEC_LSB + SEC_W;
    localparam int RSPALL_BIT = RETRY_LSB + RETRY_W;
    localparam int TXRST_BIT  = RSPALL_BIT + 1;
    localparam int RXRST_BIT  = TXRST_BIT + 1;
    localparam int BCAST_BIT  = RXRST_BIT + 1;
    localparam int USED_W     = BCAST_BIT + 1;

    localparam logic [FRAC_W-1:0]  FRAC_INIT   = 13'h0320;
    localparam logic [SEC_W-1:0]   SEC_INIT    = '0;
    localparam logic [RETRY_W-1:0] RETRY_INIT  = '0;
    localparam logic               RSPALL_INIT = 1'b1;
    localparam logic               BCAST_INIT  = 1'b0;

    typedef enum logic { RX_RUN, RX_HOLD } rx_state_t;
    typedef enum logic { TX_LIVE, TX_HELD } tx_state_t;

    typedef struct packed {
        logic               bcast;
        logic               rsp_all;
        logic [RETRY_W-1:0] retry;
        logic [SEC_W-1:0]   sec;
        logic [FRAC_W-1:0]  frac;
    } plain_t;
endpackage

// File: rtl/alc_rx_fsm.sv
module alc_rx_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_bit,
    input  logic link_idle,
    output logic rx_rst
);
    import alc_pkg::*;
    rx_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            RX_RUN:  if (wr_en && wr_bit) state_nx = RX_HOLD;        // RX_ARM
            RX_HOLD: begin
                if (wr_en && !wr_bit)     state_nx = RX_RUN;         // RX_DROP
                else if (!(wr_en && wr_bit) && link_idle)
                                          state_nx = RX_RUN;         // RX_AUTOCLR
            end
            default:                      state_nx = RX_RUN;
        endcase
    end

    always_comb rx_rst = (state == RX_HOLD);
endmodule

// File: rtl/alc_tx_fsm.sv
module alc_tx_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_bit,
    input  logic bus_reset,
    output logic tx_rst
);
    import alc_pkg::*;
    tx_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_HELD;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            TX_LIVE: begin
                if (bus_reset)             state_nx = TX_HELD;      // TX_FORCE
                else if (wr_en && wr_bit)  state_nx = TX_HELD;      // TX_SET
            end
            TX_HELD: begin
                if (bus_reset)             state_nx = TX_HELD;      // TX_FORCE
                else if (wr_en && !wr_bit) state_nx = TX_LIVE;      // TX_RELEASE
            end
            default:                       state_nx = TX_HELD;
        endcase
    end

    always_comb tx_rst = (state == TX_HELD);
endmodule

// File: rtl/alc_fields.sv
module alc_fields (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [alc_pkg::WORD_W-1:0]   wr_data,
    output alc_pkg::plain_t              fields
);
    import alc_pkg::*;
    plain_t incoming;

    always_comb begin
        incoming.bcast   = wr_data[BCAST_BIT];
        incoming.rsp_all = wr_data[RSPALL_BIT];
        incoming.retry   = wr_data[RETRY_LSB +: RETRY_W];
        incoming.sec     = wr_data[SEC_LSB +: SEC_W];
        incoming.frac    = wr_data[FRAC_LSB +: FRAC_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fields.bcast   <= BCAST_INIT;
            fields.rsp_all <= RSPALL_INIT;
            fields.retry   <= RETRY_INIT;
            fields.sec     <= SEC_INIT;
            fields.frac    <= FRAC_INIT;
        end else if (wr_en) begin
            fields <= incoming;
        end
    end
endmodule

// File: rtl/async_link_ctl.sv
module async_link_ctl (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        bus_reset,
    input  logic        link_idle,
    output logic [31:0] rd_data,
    output logic        bcast_off,
    output logic        rx_rst,
    output logic        tx_rst,
    output logic        rsp_all,
    output logic [3:0]  retry_max,
    output logic [2:0]  tmo_sec,
    output logic [12:0] tmo_frac
);
    import alc_pkg::*;
    plain_t f;

    alc_fields u_fields (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .fields(f)
    );
    alc_rx_fsm u_rx (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bit(wr_data[RXRST_BIT]),
        .link_idle(link_idle), .rx_rst(rx_rst)
    );
    alc_tx_fsm u_tx (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bit(wr_data[TXRST_BIT]),
        .bus_reset(bus_reset), .tx_rst(tx_rst)
    );

    always_comb begin
        bcast_off = f.bcast;
        rsp_all   = f.rsp_all;
        retry_max = f.retry;
        tmo_sec   = f.sec;
        tmo_frac  = f.frac;
        rd_data   = '0;
        rd_data[USED_W-1:0] = {f.bcast, rx_rst, tx_rst, f.rsp_all,
                               f.retry, f.sec, f.frac};
    end
endmodule

// File: rtl/async_link_ctl_chk.sv
module async_link_ctl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic        bus_reset,
    input logic        link_idle,
    input logic [31:0] rd_data,
    input logic        rx_rst,
    input logic        tx_rst,
    input logic [3:0]  retry_max,
    input logic [12:0] tmo_frac
);
    // R3
    always_comb if (rst_n) upper_zero_chk: assert (rd_data[31:24] == 8'h00);

    // R2
    field_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (retry_max == $past(wr_data[19:16]) && tmo_frac == $past(wr_data[12:0])));

    // R4
    rx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[22]) |=> rx_rst);

    // R5
    rx_autoclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rst && link_idle && !(wr_en && wr_data[22])) |=> !rx_rst);

    // R4
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rst && !link_idle && !wr_en) |=> rx_rst);

    // R7
    tx_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> tx_rst);

    // R8
    tx_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_reset && wr_en) |=> (tx_rst == $past(wr_data[21])));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (retry_max == $past(retry_max) && tmo_frac == $past(tmo_frac)));
endmodule

bind async_link_ctl async_link_ctl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .bus_reset(bus_reset), .link_idle(link_idle), .rd_data(rd_data),
    .rx_rst(rx_rst), .tx_rst(tx_rst), .retry_max(retry_max), .tmo_frac(tmo_frac)
);

// File: tb/async_link_ctl_test.sv
`timescale 1ns/1ps
module async_link_ctl_test;
    logic        clk = 0, rst_n = 0;
    logic        wr_en = 0, bus_reset = 0, link_idle = 0;
    logic [31:0] wr_data = 0;
    logic [31:0] rd_data;
    logic        bcast_off, rx_rst, tx_rst, rsp_all;
    logic [3:0]  retry_max;
    logic [2:0]  tmo_sec;
    logic [12:0] tmo_frac;
    int errors = 0, checks = 0;
    logic [31:0] exp_q;

    always #4 clk = ~clk;

    async_link_ctl uut (.*);

    function automatic logic [31:0] nxt(logic [31:0] cur, logic we, logic [31:0] wd,
                                        logic br, logic idle);
        logic [31:0] n = cur;
        if (we) n = wd & 32'h00FF_FFFF;
        else if (idle) n[22] = 1'b0;
        if (br) n[21] = 1'b1;
        return n;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_all(string tag);
        chk(tag, rd_data, exp_q);
        chk(tag, {8'h0, bcast_off, rx_rst, tx_rst, rsp_all, retry_max, tmo_sec, tmo_frac},
            exp_q);
    endtask

    task automatic step(logic we, logic [31:0] wd, logic br, logic idle);
        wr_en = we; wr_data = wd; bus_reset = br; link_idle = idle;
        exp_q = nxt(exp_q, we, wd, br, idle);
        @(negedge clk);
        wr_en = 0; bus_reset = 0;
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1394));
        repeat (2) @(negedge clk);
        rst_n = 1;
        exp_q = 32'h0030_0320;
        @(negedge clk);
        chk_all("R1");
        // R3: upper bits ignore writes
        step(1, 32'hFFFF_FFFF, 0, 0); chk_all("R3");
        chk("R3", {24'h0, rd_data[31:24]}, 32'h0);
        // R2: plain fields
        step(1, 32'h00A5_B7C1, 0, 0); chk_all("R2");
        // R9: no write holds
        step(0, 32'hFFFF_FFFF, 0, 0); chk_all("R9");
        // R4: set rx, hold without idle
        step(1, 32'h0040_0000, 0, 0); chk_all("R4");
        step(0, 0, 0, 0); chk_all("R4");
        // R5: idle clears
        step(0, 0, 0, 1); chk_all("R5");
        chk("R5", {31'h0, rx_rst}, 32'h0);
        // R5: write 1 with idle keeps set, then idle clears
        step(1, 32'h0040_0000, 0, 1); chk_all("R5");
        chk("R5", {31'h0, rx_rst}, 32'h1);
        step(0, 0, 0, 1); chk_all("R5");
        // R6: write 0 clears
        step(1, 32'h0040_0000, 0, 0);
        step(1, 32'h0000_0000, 0, 0); chk_all("R6");
        chk("R6", {31'h0, rx_rst}, 32'h0);
        // R7: bus reset beats write of 0
        step(1, 32'h0000_0001, 1, 0); chk_all("R7");
        chk("R7", {31'h0, tx_rst}, 32'h1);
        // R8: write 0 releases, write 1 sets
        step(1, 32'h0000_0002, 0, 0); chk_all("R8");
        chk("R8", {31'h0, tx_rst}, 32'h0);
        step(1, 32'h0020_0000, 0, 0); chk_all("R8");
        // R7: bus reset alone
        step(1, 32'h0, 0, 0);
        step(0, 0, 1, 0); chk_all("R7");
        // random mix
        for (int i = 0; i < 2000; i++) begin
            logic we, br, idle;
            logic [31:0] wd;
            we = ($urandom % 3) == 0;
            br = ($urandom % 7) == 0;
            idle = $urandom[0];
            wd = $urandom;
            step(we, wd, br, idle);
            chk_all(br ? "R7" : (we ? "R2" : "R9"));
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule